// File: doc/BRIEF.md
# Programmable Interval Timer Counter

This block is one channel of a PC-style interval timer. Software programs it over an 8-bit byte port. A control word selects how the count is accessed, which operating mode is used, and whether counting is binary or decimal. A 16-bit start value follows as two data bytes, low byte first. After that the channel counts down by one on every pulse of a timebase enable. That pulse is expected at 1,193,180 Hz. An output level, also shown as a bit in a status byte, reports the terminal count.

Only part of the full timer is built:
- 16-bit low-then-high access.
- Binary counting.
- Three modes: interrupt on terminal count, rate generator and square wave.

Any other setting in a control word raises a configuration error flag. The count can be read back live, or frozen by a latch command and then read out in two byte phases.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out_level`, `cfg_err`, `stat_byte` and `rdata` are all zero, and the mode is interrupt on terminal count.
- R2: The first data byte after a control word becomes the low byte of the start value. The next data byte becomes the high byte; it arms the counter with the full 16-bit value and points the write sequence back at the low byte.
- R3: An accepted control word does four things: it points both the write and the read byte sequence at the low byte, releases any latch, and stops counting until a new start value is written.
- R4: An armed counter drops by one on each clock with `tick` high. A start value of 0 counts as 65536.
- R5: In interrupt-on-terminal-count mode (mode field 000), `out_level` goes high on the tick that takes the count from 1 to 0. The count then stays at 0.
- R6: In rate-generator (010) and square-wave (011) modes, expiry reloads the start value and leaves `out_level` unchanged.
- R7: An accepted control word with mode 000 drives `out_level` low. One with mode 010 or 011 leaves it as it was.
- R8: A latch command (bits 5:4 = 00) copies the live count. The next two data reads return the copy's low byte and then its high byte, and the latch is then released. A latch command given while a copy is already held has no effect.
- R9: With no latch held, data reads return the live count, low byte and high byte in turn. A count of 65536 reads as 0.
- R10: A control word with access field (bits 5:4) 01 or 10 sets `cfg_err`. It has no other effect.
- R11: A control word with access field 11 and a mode field (bits 3:1) other than 000, 010 or 011 sets `cfg_err`. It has no other effect.
- R12: A control word with bit 0 (BCD) set and otherwise valid fields sets `cfg_err`. It is still applied, and counting stays binary.
- R13: A control word with access 11, a valid mode and bit 0 clear clears `cfg_err`. A latch command leaves `cfg_err` unchanged.
- R14: Bit 5 of `stat_byte` equals `out_level`, and all other bits of `stat_byte` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one count per high cycle |
| sel_ctrl | input | 1 | 1 selects the control word, 0 selects the data port |
| wr_en | input | 1 | Write strobe for `wdata` |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle and the read pointer advances |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read-back byte of the latched or live count |
| out_level | output | 1 | Counter output level |
| stat_byte | output | 8 | Status byte, with the output level in bit 5 |
| cfg_err | output | 1 | Unsupported configuration flag |

## Verification
The countdown is tried with several kinds of start value:
- A zero start value, which checks the 65536 case. The output is checked one tick before and at expiry.
- Random small values in every supported mode, with random tick counts that cross expiry once or twice. These separate a one-shot stop from a periodic reload.

Latch readback is compared with the live count a few ticks later, which shows that the copy is a snapshot and not the live count. Each kind of invalid control word is sent while counting is under way. The count read back afterwards shows that nothing but the error flag changed. A BCD request with a start value of 0x10 separates binary counting (16 ticks) from decimal counting (10 ticks).

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        MODE_TC   = 3'd0,
        MODE_RATE = 3'd2,
        MODE_SQW  = 3'd3
    } pit_mode_e;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } pit_acc_e;

    typedef struct packed {
        logic      latch_cmd;
        logic      accept;
        logic      err;
        pit_mode_e mode;
    } pit_cw_t;

endpackage

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
    import pit_pkg::*;
(
    input  logic [5:0] cw,
    output pit_cw_t    dec
);
    pit_acc_e acc;
    logic     mode_ok;
    logic     acc_ok;

    always_comb begin
        acc     = pit_acc_e'(cw[5:4]);
        mode_ok = (cw[3:1] == MODE_TC) || (cw[3:1] == MODE_RATE) || (cw[3:1] == MODE_SQW);
        acc_ok  = (acc == ACC_LOHI);
        dec.latch_cmd = (acc == ACC_LATCH);
        dec.accept    = acc_ok && mode_ok;
        dec.err       = (acc != ACC_LATCH) && (!acc_ok || !mode_ok || cw[0]);
        dec.mode      = mode_ok ? pit_mode_e'(cw[3:1]) : MODE_TC;
    end
endmodule

// File: rtl/pit_decr.sv
module pit_decr #(
    parameter int CNT_X = 17
) (
    input  logic [CNT_X-1:0] count,
    input  logic [CNT_X-1:0] period,
    input  logic             one_shot,
    output logic             expire,
    output logic [CNT_X-1:0] count_nxt
);
    always_comb begin
        expire = (count == CNT_X'(1));
        if (expire) begin
            count_nxt = one_shot ? '0 : period;
        end else begin
            count_nxt = count - CNT_X'(1);
        end
    end
endmodule

// File: rtl/pit_rd_sel.sv
module pit_rd_sel #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] live,
    input  logic [2*BYTE_W-1:0] held,
    input  logic                use_held,
    input  logic                hi_phase,
    output logic [BYTE_W-1:0]   byte_out
);
    logic [2*BYTE_W-1:0] src;

    always_comb begin
        src      = use_held ? held : live;
        byte_out = hi_phase ? src[2*BYTE_W-1:BYTE_W] : src[BYTE_W-1:0];
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SPKR_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sel_ctrl,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              out_level,
    output logic [BYTE_W-1:0] stat_byte,
    output logic              cfg_err
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int CNT_X = CNT_W + 1;
    localparam logic [CNT_X-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        pit_mode_e         mode;
        logic              armed;
        logic [CNT_X-1:0]  count;
        logic [CNT_X-1:0]  period;
        logic [BYTE_W-1:0] lo_byte;
        logic              wr_hi;
        logic              rd_hi;
        logic              latch_on;
        logic [CNT_W-1:0]  latch_val;
        logic              out;
        logic              err;
    } chan_state_t;

    chan_state_t       state_d, state_q;
    pit_cw_t           cw_dec;
    logic              dec_expire;
    logic [CNT_X-1:0]  dec_next;
    logic [CNT_X-1:0]  load_val;

    pit_cw_decode u_cw_decode (
        .cw  (wdata[5:0]),
        .dec (cw_dec)
    );

    pit_decr #(.CNT_X(CNT_X)) u_decr (
        .count     (state_q.count),
        .period    (state_q.period),
        .one_shot  (state_q.mode == MODE_TC),
        .expire    (dec_expire),
        .count_nxt (dec_next)
    );

    pit_rd_sel #(.BYTE_W(BYTE_W)) u_rd_sel (
        .live     (state_q.count[CNT_W-1:0]),
        .held     (state_q.latch_val),
        .use_held (state_q.latch_on),
        .hi_phase (state_q.rd_hi),
        .byte_out (rdata)
    );

    always_comb begin
        load_val = {1'b0, wdata, state_q.lo_byte};
        if (load_val == '0) begin
            load_val = FULL_CNT;
        end
    end

    always_comb begin
        state_d = state_q;

        // countdown on the timebase enable
        if (tick && state_q.armed) begin
            state_d.count = dec_next;
            if (dec_expire && state_q.mode == MODE_TC) begin
                state_d.out   = 1'b1;
                state_d.armed = 1'b0;
            end
        end

        // control word
        if (wr_en && sel_ctrl) begin
            if (cw_dec.latch_cmd) begin
                if (!state_q.latch_on) begin
                    state_d.latch_on  = 1'b1;
                    state_d.latch_val = state_q.count[CNT_W-1:0];
                end
            end else begin
                state_d.err = cw_dec.err;
                if (cw_dec.accept) begin
                    state_d.mode     = cw_dec.mode;
                    state_d.wr_hi    = 1'b0;
                    state_d.rd_hi    = 1'b0;
                    state_d.latch_on = 1'b0;
                    state_d.armed    = 1'b0;
                    if (cw_dec.mode == MODE_TC) begin
                        state_d.out = 1'b0;
                    end
                end
            end
        end

        // data byte write, low then high
        if (wr_en && !sel_ctrl) begin
            if (!state_q.wr_hi) begin
                state_d.lo_byte = wdata;
                state_d.wr_hi   = 1'b1;
            end else begin
                state_d.count  = load_val;
                state_d.period = load_val;
                state_d.armed  = 1'b1;
                state_d.wr_hi  = 1'b0;
            end
        end

        // data byte read, low then high
        if (rd_en) begin
            state_d.rd_hi = !state_q.rd_hi;
            if (state_q.rd_hi && state_q.latch_on) begin
                state_d.latch_on = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        stat_byte           = '0;
        stat_byte[SPKR_BIT] = state_q.out;
    end

    assign out_level = state_q.out;
    assign cfg_err   = state_q.err;

    logic             chk_armed;
    logic [CNT_X-1:0] chk_count;
    logic             chk_latched;
    logic             chk_rd_hi;
    logic             chk_periodic;

    assign chk_armed    = state_q.armed;
    assign chk_count    = state_q.count;
    assign chk_latched  = state_q.latch_on;
    assign chk_rd_hi    = state_q.rd_hi;
    assign chk_periodic = (state_q.mode != MODE_TC);

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
    parameter int CNT_X = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             sel_ctrl,
    input logic             wr_en,
    input logic             rd_en,
    input logic [4:0]       cw,
    input logic             out_level,
    input logic             cfg_err,
    input logic             armed,
    input logic [CNT_X-1:0] count,
    input logic             latched,
    input logic             rd_hi,
    input logic             periodic
);
    localparam logic [CNT_X-1:0] FULL_CNT = {1'b1, {(CNT_X-1){1'b0}}};

    // R10
    acc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && (cw[4:3] == 2'b01 || cw[4:3] == 2'b10)) |=> cfg_err);

    // R7
    tc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && cw[4:3] == 2'b11 && cw[2:0] == 3'b000) |=> !out_level);

    // R5
    out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_level) |-> ($past(tick) && !$past(periodic)));

    // R6
    periodic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(periodic) && !$past(wr_en && sel_ctrl)) |-> $stable(out_level));

    // R4
    armed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (count != '0 && count <= FULL_CNT));

    // R8
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && latched && rd_hi) |=> !latched);

    // R13
    latch_keeps_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && cw[4:3] == 2'b00) |=> $stable(cfg_err));

endmodule

bind pit_channel pit_channel_chk #(.CNT_X(CNT_X)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sel_ctrl  (sel_ctrl),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .cw        (wdata[5:1]),
    .out_level (out_level),
    .cfg_err   (cfg_err),
    .armed     (chk_armed),
    .count     (chk_count),
    .latched   (chk_latched),
    .rd_hi     (chk_rd_hi),
    .periodic  (chk_periodic)
);

// File: tb/test_pit_channel.sv
module test_pit_channel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       out_level;
    logic [7:0] stat_byte;
    logic       cfg_err;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_channel i_pit_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_ctrl(sel_ctrl),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .out_level(out_level), .stat_byte(stat_byte), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic ctrl, input logic [7:0] b);
        sel_ctrl = ctrl; wdata = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sel_ctrl = 1'b0;
    endtask

    task automatic load(input int v);
        wr(1'b0, 8'(v));
        wr(1'b0, 8'(v >> 8));
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic rd(output logic [7:0] b);
        b = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi;
        rd(lo);
        rd(hi);
        v = {16'h0, hi, lo};
    endtask

    function automatic int exp_cnt(input int mode, input int n, input int k);
        int r;
        if (mode == 0) begin
            r = (k >= n) ? 0 : n - k;
        end else begin
            r = k % n;
            r = (r == 0) ? n : n - r;
        end
        return r & 16'hFFFF;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int v;
        logic [7:0] b;
        logic exp_out;
        int unsigned seed;
        seed = $urandom(32'h5EED);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 out", out_level, 0);
        check("R1 err", cfg_err, 0);
        check("R1 stat", stat_byte, 0);
        check("R1 rdata", rdata, 0);

        // R4/R5 zero start value means 65536, one-shot
        wr(1'b1, 8'h30);
        load(0);
        rd16(v);
        check("R9 full count reads 0", v, 0);
        ticks(65535);
        check("R4 65536 not yet expired", out_level, 0);
        check("R14 stat low", stat_byte, 8'h00);
        ticks(1);
        check("R5 expire out high", out_level, 1);
        check("R14 stat high", stat_byte, 8'h20);
        ticks(5);
        rd16(v);
        check("R5 count held at 0", v, 0);

        // R7 periodic control word leaves out high
        wr(1'b1, 8'h34);
        check("R7 periodic cw keeps out", out_level, 1);
        check("R13 valid cw err clear", cfg_err, 0);

        // R2/R3 write pointer reset by control word
        wr(1'b0, 8'h55);
        wr(1'b1, 8'h34);
        load(16'h0305);
        rd16(v);
        check("R2 R3 write pointer reset", v, 16'h0305);
        rd(b);
        wr(1'b1, 8'h36);
        rd(b);
        check("R3 read pointer reset", b, 8'h05);

        // R6 periodic reload, out unchanged
        wr(1'b1, 8'h34);
        load(4);
        ticks(4);
        rd16(v);
        check("R6 reload", v, 4);
        check("R6 out unchanged", out_level, 1);
        ticks(1);

        // R10 invalid access ignored
        wr(1'b1, 8'h10);
        check("R10 err set", cfg_err, 1);
        check("R10 out untouched", out_level, 1);
        ticks(1);
        rd16(v);
        check("R10 counting continues", v, 2);
        wr(1'b1, 8'h20);
        check("R10 err set hi access", cfg_err, 1);

        // R13, R11
        wr(1'b1, 8'h34);
        check("R13 err cleared", cfg_err, 0);
        wr(1'b1, 8'h3A);
        check("R11 mode 5 err", cfg_err, 1);
        wr(1'b1, 8'h00);
        check("R13 latch keeps err", cfg_err, 1);
        rd16(v);
        check("R8 latched read", v, 2);
        wr(1'b1, 8'h3C);
        check("R11 mode 6 err", cfg_err, 1);

        // R12 BCD: applied, binary counting
        wr(1'b1, 8'h31);
        check("R12 bcd err", cfg_err, 1);
        check("R7 tc cw drives low", out_level, 0);
        load(16'h0010);
        ticks(10);
        check("R12 not decimal", out_level, 0);
        rd16(v);
        check("R12 binary count", v, 6);
        ticks(6);
        check("R12 binary expiry", out_level, 1);

        // R8 double latch ignored
        wr(1'b1, 8'h34);
        load(16'h1234);
        ticks(16);
        wr(1'b1, 8'h00);
        ticks(5);
        wr(1'b1, 8'h00);
        ticks(5);
        rd16(v);
        check("R8 snapshot kept", v, 16'h1224);
        rd16(v);
        check("R9 live after release", v, 16'h121A);
        exp_out = 1'b1;

        // random loads across modes
        for (int it = 0; it < 20; it++) begin
            int mode, n, k, sel;
            sel = $urandom_range(0, 2);
            mode = (sel == 0) ? 0 : sel + 1;
            n = $urandom_range(2, 400);
            k = (mode == 0) ? $urandom_range(0, n + 3) : $urandom_range(0, 2 * n + 5);
            wr(1'b1, 8'(8'h30 | (mode << 1)));
            load(n);
            ticks(k);
            wr(1'b1, 8'h00);
            ticks(3);
            rd16(v);
            check("R8 random latch", v, exp_cnt(mode, n, k));
            rd16(v);
            check("R4 R9 random live", v, exp_cnt(mode, n, k + 3));
            if (mode == 0) exp_out = (k + 3 >= n);
            check("R5 R6 random out", out_level, exp_out);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule